// File: doc/BRIEF.md
# Configurable Vector Post-Processing Pipeline

This block sits behind a systolic matrix array and processes one vector of signed Q8.8 values per beat. Each beat carries, lane by lane, a data element, a bias element and a target element, all qualified by a single valid strobe. Three optional stages are chained: a saturating bias adder, an activation stage, and a mean-squared-error gradient stage. The activation stage works either as a Leaky ReLU with a programmable slope or, for backpropagation, as the derivative of that activation.

A 4-bit pathway code picks the active stages. A stage that is not in use becomes a plain wire, so each beat is delayed by exactly the number of stages that are enabled. Two runtime operands steer the arithmetic: the leak slope and a precomputed loss scale equal to 2/N for a batch of N. The pathway code and both operands must stay stable while any beat is inside the pipeline.

Top module: `vpp_top`

## Requirements
- R1: Every data, bias, target, leak and scale value is a 16-bit two's-complement Q8.8 number. The bias stage outputs data plus bias, clamped to the range 0x8000..0x7FFF.
- R2: With pathway code 4'b0000, outData equals inData and outValid equals inValid in the same cycle.
- R3: Every pathway code other than 4'b0000, 4'b0001, 4'b1100 and 4'b1111 behaves exactly like 4'b0000.
- R4: With code 4'b0001 only the derivative stage runs. Each lane outputs 0x0100 when its input is strictly positive and the leak factor otherwise, one cycle after the input beat.
- R5: With code 4'b1100 the bias stage runs, then the Leaky ReLU stage, and each result appears two cycles after its input beat.
- R6: In the Leaky ReLU stage a non-negative value passes unchanged and a negative value becomes the fractional product of that value and the leak factor. A leak of 0x0000 therefore gives plain ReLU (no negative output), and 0x0080 gives a slope of one half.
- R7: With code 4'b1111 the loss stage follows the Leaky ReLU. Its output is the fractional product of (activation − target, clamped to 16 bits) and the loss scale, three cycles after the input beat.
- R8: A fractional product takes the full signed 32-bit product, shifts it right by 8 with rounding toward minus infinity, and clamps the result to 0x8000..0x7FFF.
- R9: outValid repeats inValid delayed by the number of active stages. Back-to-back and gapped beats all emerge in order, with no beat lost or added.
- R10: While reset is asserted, and after it until the first beat has crossed the pipeline, outValid stays low in every registered mode, even if inValid is high during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pathCode | input | 4 | Pathway code selecting the active stages |
| leakFactor | input | 16 | Leaky ReLU slope, Q8.8 |
| lossScale | input | 16 | Loss scale 2/N, Q8.8 |
| inValid | input | 1 | Input beat valid |
| inData | input | LANES*16 | Data elements, lane 0 in the low bits |
| inBias | input | LANES*16 | Bias elements, one per lane |
| inTarget | input | LANES*16 | Target elements, one per lane |
| outValid | output | 1 | Output beat valid |
| outData | output | LANES*16 | Result elements, one per lane |

## Verification
The bench builds the block with two lanes at the default 16-bit Q8.8 width, so every beat exercises both lanes at once. With this small configuration, a sweep of 4096 beats steps each lane's input through the whole signed 16-bit range in strides of 16. Biases and targets are pushed to both extremes often enough to reach the clamps of the adder, the subtractor and the multiplier, and several leak and scale values are applied, including negative and full-scale ones. Beats are sent back to back and with gaps, so the variable latency of each pathway is checked against an in-order queue of expected results.

// File: rtl/vpp_pkg.sv
package vpp_pkg;

  typedef enum logic [3:0] {
    PATH_PASS     = 4'b0000,
    PATH_DERIV    = 4'b0001,
    PATH_FWD      = 4'b1100,
    PATH_FWD_LOSS = 4'b1111
  } path_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic biasEn;
    logic actEn;
    logic derivEn;
    logic lossEn;
    logic ldA;
    logic ldB;
    logic ldC;
  } vpp_strobe_t;

endpackage

// File: rtl/vpp_ctrl.sv
module vpp_ctrl
  import vpp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  pathCode,
  input  logic        inValid,
  output vpp_strobe_t stb,
  output logic        outValid
);

  logic biasEn, actEn, derivEn, lossEn;
  logic vaQ, vbQ, vcQ;
  logic vaOut, vbOut;

  // Decode: only four codes enable stages, all others fall back to pass-through
  always_comb begin
    biasEn  = 1'b0;
    actEn   = 1'b0;
    derivEn = 1'b0;
    lossEn  = 1'b0;
    case (pathCode)
      PATH_DERIV:    derivEn = 1'b1;
      PATH_FWD:      begin biasEn = 1'b1; actEn = 1'b1; end
      PATH_FWD_LOSS: begin biasEn = 1'b1; actEn = 1'b1; lossEn = 1'b1; end
      default:       ;
    endcase
  end

  assign vaOut = biasEn ? vaQ : inValid;
  assign vbOut = (actEn | derivEn) ? vbQ : vaOut;
  assign outValid = lossEn ? vcQ : vbOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ <= 1'b0;
      vbQ <= 1'b0;
      vcQ <= 1'b0;
    end else begin
      vaQ <= inValid & biasEn;
      vbQ <= vaOut & (actEn | derivEn);
      vcQ <= vbOut & lossEn;
    end
  end

  always_comb begin
    stb.biasEn  = biasEn;
    stb.actEn   = actEn;
    stb.derivEn = derivEn;
    stb.lossEn  = lossEn;
    stb.ldA     = inValid & biasEn;
    stb.ldB     = vaOut & (actEn | derivEn);
    stb.ldC     = vbOut & lossEn;
  end

endmodule

// File: rtl/vpp_lane.sv
module vpp_lane
  import vpp_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic          clk,
  input  vpp_strobe_t   stb,
  input  logic [DW-1:0] xIn,
  input  logic [DW-1:0] bIn,
  input  logic [DW-1:0] tIn,
  input  logic [DW-1:0] leak,
  input  logic [DW-1:0] scale,
  output logic [DW-1:0] yOut
);

  localparam int PW = 2 * DW;
  localparam int XW = PW - DW + 2;
  localparam logic [DW-1:0] ONE  = DW'(1) << FW;
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [PW:0] sext(input logic [DW-1:0] a);
    return {{(PW-DW+1){a[DW-1]}}, a};
  endfunction

  function automatic logic [DW-1:0] clampW(input logic [PW:0] v);
    if (v[PW:DW-1] == {XW{1'b0}} || v[PW:DW-1] == {XW{1'b1}})
      return v[DW-1:0];
    else if (v[PW])
      return MINV;
    else
      return MAXV;
  endfunction

  function automatic logic [DW-1:0] qmul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shf;
    prod = $signed(sext(a)) * $signed(sext(b));
    shf  = prod >>> FW;
    return clampW({shf[PW-1], shf});
  endfunction

  // Stage A: bias add
  logic [DW-1:0] aSum, aData, aTgt, aOut, aTgtOut;
  assign aSum = clampW(sext(xIn) + sext(bIn));

  always_ff @(posedge clk) begin
    if (stb.ldA) begin
      aData <= aSum;
      aTgt  <= tIn;
    end
  end

  assign aOut    = stb.biasEn ? aData : xIn;
  assign aTgtOut = stb.biasEn ? aTgt  : tIn;

  // Stage B: Leaky ReLU or its derivative
  logic [DW-1:0] bRes, bData, bTgt, bOut, bTgtOut;

  always_comb begin
    if (stb.derivEn)
      bRes = ($signed(aOut) > 0) ? ONE : leak;
    else if (aOut[DW-1])
      bRes = qmul(aOut, leak);
    else
      bRes = aOut;
  end

  always_ff @(posedge clk) begin
    if (stb.ldB) begin
      bData <= bRes;
      bTgt  <= aTgtOut;
    end
  end

  assign bOut    = (stb.actEn | stb.derivEn) ? bData : aOut;
  assign bTgtOut = (stb.actEn | stb.derivEn) ? bTgt  : aTgtOut;

  // Stage C: loss gradient
  logic [DW-1:0] diff, cRes, cData;
  assign diff = clampW(sext(bOut) - sext(bTgtOut));
  assign cRes = qmul(diff, scale);

  always_ff @(posedge clk) begin
    if (stb.ldC) cData <= cRes;
  end

  assign yOut = stb.lossEn ? cData : bOut;

endmodule

// File: rtl/vpp_datapath.sv
module vpp_datapath
  import vpp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int FW    = 8
) (
  input  logic              clk,
  input  vpp_strobe_t       stb,
  input  logic [DW-1:0]     leak,
  input  logic [DW-1:0]     scale,
  input  logic [LANES*DW-1:0] xVec,
  input  logic [LANES*DW-1:0] bVec,
  input  logic [LANES*DW-1:0] tVec,
  output logic [LANES*DW-1:0] yVec
);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    vpp_lane #(.DW(DW), .FW(FW)) uLane (
      .clk   (clk),
      .stb   (stb),
      .xIn   (xVec[g*DW +: DW]),
      .bIn   (bVec[g*DW +: DW]),
      .tIn   (tVec[g*DW +: DW]),
      .leak  (leak),
      .scale (scale),
      .yOut  (yVec[g*DW +: DW])
    );
  end

endmodule

// File: rtl/vpp_top.sv
module vpp_top
  import vpp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int FW    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          pathCode,
  input  logic [DW-1:0]       leakFactor,
  input  logic [DW-1:0]       lossScale,
  input  logic                inValid,
  input  logic [LANES*DW-1:0] inData,
  input  logic [LANES*DW-1:0] inBias,
  input  logic [LANES*DW-1:0] inTarget,
  output logic                outValid,
  output logic [LANES*DW-1:0] outData
);

  vpp_strobe_t stb;

  vpp_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pathCode (pathCode),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  vpp_datapath #(.LANES(LANES), .DW(DW), .FW(FW)) uPath (
    .clk   (clk),
    .stb   (stb),
    .leak  (leakFactor),
    .scale (lossScale),
    .xVec  (inData),
    .bVec  (inBias),
    .tVec  (inTarget),
    .yVec  (outData)
  );

endmodule

// File: rtl/vpp_checker.sv
module vpp_checker #(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int FW    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [3:0]          pathCode,
  input logic [DW-1:0]       leakFactor,
  input logic                inValid,
  input logic [LANES*DW-1:0] inData,
  input logic                outValid,
  input logic [LANES*DW-1:0] outData
);

  localparam logic [DW-1:0] ONE = DW'(1) << FW;

  logic listed;
  assign listed = (pathCode == 4'b0000) || (pathCode == 4'b0001) ||
                  (pathCode == 4'b1100) || (pathCode == 4'b1111);

  // R2
  p_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pathCode == 4'b0000) |-> (outValid == inValid && outData == inData));

  // R3
  p_unlisted_r3: assert property (@(posedge clk) disable iff (!rstN)
    !listed |-> (outValid == inValid && outData == inData));

  // R4 / R9
  p_deriv_lat_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pathCode == 4'b0001 && $past(pathCode) == 4'b0001 && $past(rstN))
      |-> (outValid == $past(inValid)));

  // R5 / R9
  p_fwd_lat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pathCode == 4'b1100 && $past(pathCode) == 4'b1100 &&
     $past(pathCode, 2) == 4'b1100 && $past(rstN, 2))
      |-> (outValid == $past(inValid, 2)));

  // R7 / R9
  p_loss_lat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pathCode == 4'b1111 && $past(pathCode) == 4'b1111 &&
     $past(pathCode, 2) == 4'b1111 && $past(pathCode, 3) == 4'b1111 &&
     $past(rstN, 3))
      |-> (outValid == $past(inValid, 3)));

  for (genvar g = 0; g < LANES; g++) begin : gLaneChk
    // R4
    p_deriv_val_r4: assert property (@(posedge clk) disable iff (!rstN)
      (pathCode == 4'b0001 && $past(pathCode) == 4'b0001 && $past(rstN) && outValid)
        |-> (outData[g*DW +: DW] ==
             (($signed($past(inData[g*DW +: DW])) > 0) ? ONE : $past(leakFactor))));

    // R6
    p_relu_nonneg_r6: assert property (@(posedge clk) disable iff (!rstN)
      (pathCode == 4'b1100 && $past(pathCode) == 4'b1100 && $past(rstN) &&
       outValid && $past(leakFactor) == '0)
        |-> !outData[g*DW + DW - 1]);
  end

endmodule

bind vpp_top vpp_checker #(.LANES(LANES), .DW(DW), .FW(FW)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .pathCode   (pathCode),
  .leakFactor (leakFactor),
  .inValid    (inValid),
  .inData     (inData),
  .outValid   (outValid),
  .outData    (outData)
);

// File: tb/sim_vpp_top.sv
`timescale 1ns/1ps
module sim_vpp_top;

  localparam int LANES = 2;
  localparam int DW    = 16;
  localparam int VW    = LANES * DW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    pathCode = 4'b1100;
  logic [DW-1:0] leakFactor = '0;
  logic [DW-1:0] lossScale = '0;
  logic          inValid = 1'b0;
  logic [VW-1:0] inData = '0, inBias = '0, inTarget = '0;
  logic          outValid;
  logic [VW-1:0] outData;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;
  string curTag = "R2";
  logic [VW-1:0] expQ[$];

  always #2 clk = ~clk;

  vpp_top #(.LANES(LANES), .DW(DW), .FW(8)) u0 (
    .clk(clk), .rstN(rstN), .pathCode(pathCode), .leakFactor(leakFactor),
    .lossScale(lossScale), .inValid(inValid), .inData(inData), .inBias(inBias),
    .inTarget(inTarget), .outValid(outValid), .outData(outData)
  );

  function automatic int clampI(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Q8.8 product, floor division by 256, then clamp
  function automatic int qm(int a, int b);
    int p;
    p = a * b;
    if (p >= 0) return clampI(p / 256);
    return clampI(-((-p + 255) / 256));
  endfunction

  function automatic int sx(logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [DW-1:0] expLane(logic [3:0] code, logic [DW-1:0] x,
                                            logic [DW-1:0] b, logic [DW-1:0] t);
    int z;
    case (code)
      4'b0001: z = (sx(x) > 0) ? 256 : sx(leakFactor);
      4'b1100, 4'b1111: begin
        z = clampI(sx(x) + sx(b));
        if (z < 0) z = qm(z, sx(leakFactor));
        if (code == 4'b1111) z = qm(clampI(z - sx(t)), sx(lossScale));
      end
      default: z = sx(x);
    endcase
    return DW'(z);
  endfunction

  task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Output monitor, away from the rising edge
  always @(negedge clk) begin
    if (rstN && outValid && !finished) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", 16'h1, 16'h0, "valid with no beat pending");
      end else begin
        logic [VW-1:0] e;
        e = expQ.pop_front();
        for (int l = 0; l < LANES; l++)
          check(outData[l*DW +: DW] == e[l*DW +: DW], curTag,
                outData[l*DW +: DW], e[l*DW +: DW], $sformatf("lane %0d", l));
      end
    end
  end

  task automatic runMode(logic [3:0] code, logic [DW-1:0] lk, logic [DW-1:0] sc,
                         int beats, int seed, string tag);
    @(posedge clk); #1;
    pathCode = code; leakFactor = lk; lossScale = sc; curTag = tag;
    for (int k = 0; k < beats; k++) begin
      @(posedge clk); #1;
      if ((k % 11) == 5) begin
        inValid = 1'b0;
      end else begin
        logic [VW-1:0] e;
        for (int l = 0; l < LANES; l++) begin
          logic [DW-1:0] x, b, t;
          x = DW'(k * 16 + l * 8 + seed - 32768);
          b = DW'(k * 7919 + l * 3 + seed * 5);
          t = DW'(k * 211 + l * 77 + seed);
          if ((k % 64) == 0) b = 16'h7FFF;
          if ((k % 64) == 1) b = 16'h8000;
          if ((k % 97) == 3) t = (l == 0) ? 16'h8000 : 16'h7FFF;
          inData[l*DW +: DW]   = x;
          inBias[l*DW +: DW]   = b;
          inTarget[l*DW +: DW] = t;
          e[l*DW +: DW] = expLane(code, x, b, t);
        end
        inValid = 1'b1;
        expQ.push_back(e);
      end
    end
    @(posedge clk); #1;
    inValid = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    check(expQ.size() == 0, "R9", DW'(expQ.size()), 16'h0, "beats missing after drain");
    expQ.delete();
  endtask

  initial begin
    // R10: reset state, inValid high during reset in a registered mode
    inValid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R10", {15'd0, outValid}, 16'h0, "outValid in reset");
    inValid = 1'b0;
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R10", {15'd0, outValid}, 16'h0, "outValid after reset");

    runMode(4'b0000, 16'h0080, 16'h0080, 512, 3, "R2");
    runMode(4'b0101, 16'h0080, 16'h0080, 256, 7, "R3");
    runMode(4'b1000, 16'h0000, 16'h0010, 256, 9, "R3");
    runMode(4'b1110, 16'h0019, 16'h0080, 256, 1, "R3");
    runMode(4'b0001, 16'h0080, 16'h0000, 1024, 5, "R4");
    runMode(4'b0001, 16'hFF00, 16'h0000, 1024, 2, "R4");
    runMode(4'b1100, 16'h0000, 16'h0000, 4096, 0, "R5/R6/R1");
    runMode(4'b1100, 16'h0080, 16'h0000, 4096, 4, "R5/R6/R1");
    runMode(4'b1100, 16'h0019, 16'h0000, 4096, 6, "R5/R6/R8");
    runMode(4'b1100, 16'hFF60, 16'h0000, 4096, 8, "R5/R6/R8");
    runMode(4'b1111, 16'h0080, 16'h0080, 4096, 1, "R7/R8");
    runMode(4'b1111, 16'h0019, 16'h0010, 4096, 3, "R7/R8");
    runMode(4'b1111, 16'h00A0, 16'h7FFF, 4096, 5, "R7/R8");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule